// File: doc/BRIEF.md
# Pipelined Converter Digital Alignment and Correction

This block is the digital back end of a 10-bit pipelined analog-to-digital converter. Every clock it receives a 2-bit decision code from each of eight redundant pipeline stages and a 2-bit code from a final flash stage. The stages sample half a clock apart, one after the next. The odd-numbered stages are captured on the rising edge and the even-numbered stages on the falling edge. All codes are then moved into the rising-edge domain.

A per-stage delay line holds the early stages' codes until the flash code of the same analog sample arrives. The nine aligned codes are added with a one-bit overlap between neighbouring stages, which cancels the stages' decision errors. The sum is clamped to ten bits.

The corrected word goes through two output registers. On its way it is formatted as offset binary or two's complement, as a select input chooses. A sample's word appears seven clocks after the sample is taken, and a new word follows on every clock after that.

Top module: `pa_backend_top`

## Requirements
- R1: Stage k (k = 1..8) presents its code on `stage_codes[2k-1:2k-2]`, and the flash stage presents its code on `flash_code`. Each code is an unsigned 2-bit value 0..3.
- R2: For analog sample n, the code of stage k is captured on half-clock 2n+k-1, where half-clock 2m is rising edge m and 2m+1 is the falling edge that follows it. This places odd stages on rising edges and even stages on falling edges. The flash code of sample n is captured on rising edge n+4.
- R3: The nine codes belonging to one analog sample are combined together. Codes from other samples are never mixed into its result.
- R4: The word for sample n is on `data_out` after rising edge n+7, and a new word follows after every later rising edge.
- R5: The corrected value is the sum over k of code_k·2^(9-k), plus the flash code with weight 1.
- R6: A corrected value above 1023 is output as 1023 (before formatting).
- R7: When `fmt_twos` is low at the rising edge one clock before a word appears, the word is offset binary. When it is high, bit 9 of the word is inverted (two's complement) and bits 8..0 are unchanged.
- R8: While `rst_n` is low, `data_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; both edges are used for stage capture |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_codes | input | 16 | Codes of stages 1..8, two bits per stage, stage 1 in the low bits |
| flash_code | input | 2 | Code of the final flash stage |
| fmt_twos | input | 1 | Output format: low for offset binary, high for two's complement |
| data_out | output | 10 | Corrected, formatted output word |

## Verification
The assertions assume the following about the inputs:
- Each odd stage's code and the flash code are settled across the rising edge.
- Each even stage's code is settled across the falling edge.
- Reset is held for several clocks and released away from both clock edges.

The bench meets these assumptions in its drive timing. It updates the even-stage codes just after each rising edge. It updates the odd-stage codes, the flash code and the format select just after each falling edge. Each input carries the value that an ideal staggered pipeline would show for the sample whose capture instant comes next.

The stimulus mixes the following:
- uniformly random codes;
- all-zero and all-three runs;
- sums just below, at and above the 10-bit ceiling;
- format select toggles.

// File: rtl/pa_pkg.sv
package pa_pkg;

   // Delay (in rising-edge cycles) that lane i (stage i+1) needs to meet the flash code
   function automatic int lane_delay(input int num_stages, input int lane);
      return (num_stages / 2) - ((lane + 1) / 2);
   endfunction

   // Total clocks from stage-1 capture to the output bus
   function automatic int total_latency(input int num_stages);
      return (num_stages / 2) + 3;
   endfunction

endpackage

// File: rtl/pa_stage_capture.sv
module pa_stage_capture #(
   parameter int NUM_STAGES = 8,
   parameter int CODE_W     = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_STAGES*CODE_W-1:0] stage_codes_i,
   input  logic [CODE_W-1:0]            flash_i,
   output logic [NUM_STAGES*CODE_W-1:0] rise_codes_o,
   output logic [CODE_W-1:0]            flash_o
);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_STAGES; gi++) begin : g_lane
         if ((gi % 2) == 0) begin : g_rise
            // odd-numbered stage: sampled directly on the rising edge
            logic [CODE_W-1:0] cap_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) cap_q <= '0;
               else        cap_q <= stage_codes_i[gi*CODE_W +: CODE_W];
            end
            assign rise_codes_o[gi*CODE_W +: CODE_W] = cap_q;
         end else begin : g_fall
            // even-numbered stage: sampled on the falling edge, then moved to rising domain
            logic [CODE_W-1:0] fall_q;
            logic [CODE_W-1:0] rer_q;
            always_ff @(negedge clk or negedge rst_n) begin
               if (!rst_n) fall_q <= '0;
               else        fall_q <= stage_codes_i[gi*CODE_W +: CODE_W];
            end
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) rer_q <= '0;
               else        rer_q <= fall_q;
            end
            assign rise_codes_o[gi*CODE_W +: CODE_W] = rer_q;
         end
      end
   endgenerate

   logic [CODE_W-1:0] flash_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flash_q <= '0;
      else        flash_q <= flash_i;
   end
   assign flash_o = flash_q;

endmodule

// File: rtl/pa_align_delay.sv
module pa_align_delay #(
   parameter int WIDTH = 2,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      if (DEPTH == 0) begin : g_pass
         assign dout = din;
      end else begin : g_shift
         logic [WIDTH-1:0] sr_q [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int d = 0; d < DEPTH; d++) sr_q[d] <= '0;
            end else begin
               sr_q[0] <= din;
               for (int d = 1; d < DEPTH; d++) sr_q[d] <= sr_q[d-1];
            end
         end
         assign dout = sr_q[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/pa_overlap_add.sv
module pa_overlap_add #(
   parameter int NUM_STAGES = 8,
   parameter int CODE_W     = 2,
   parameter int OUT_W      = 10
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_STAGES*CODE_W-1:0] aligned_i,
   input  logic [CODE_W-1:0]            flash_i,
   output logic [OUT_W-1:0]             sat_o
);

   localparam int SUM_W = OUT_W + 1;
   localparam logic [SUM_W-1:0] MAXV = SUM_W'((1 << OUT_W) - 1);

   logic [SUM_W-1:0] raw_sum;
   logic [OUT_W-1:0] sat_q;

   always_comb begin
      raw_sum = SUM_W'(flash_i);
      for (int i = 0; i < NUM_STAGES; i++) begin
         // stage i+1 carries weight 2^(NUM_STAGES-i); one bit overlaps the next stage
         raw_sum = raw_sum + (SUM_W'(aligned_i[i*CODE_W +: CODE_W]) << (NUM_STAGES - i));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               sat_q <= '0;
      else if (raw_sum > MAXV)  sat_q <= '1;
      else                      sat_q <= raw_sum[OUT_W-1:0];
   end

   assign sat_o = sat_q;

   // R6
   clamp_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_sum > MAXV) |=> (sat_q == MAXV[OUT_W-1:0]));

   // R5
   zero_in_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((aligned_i == '0) && (flash_i == '0)) |=> (sat_q == '0));

endmodule

// File: rtl/pa_format_out.sv
module pa_format_out #(
   parameter int OUT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OUT_W-1:0] sat_i,
   input  logic             fmt_twos_i,
   output logic [OUT_W-1:0] data_o
);

   logic [OUT_W-1:0] stage_a_q;
   logic [OUT_W-1:0] stage_b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_a_q <= '0;
         stage_b_q <= '0;
      end else begin
         stage_a_q <= {sat_i[OUT_W-1] ^ fmt_twos_i, sat_i[OUT_W-2:0]};
         stage_b_q <= stage_a_q;
      end
   end

   assign data_o = stage_b_q;

endmodule

// File: rtl/pa_backend_top.sv
module pa_backend_top #(
   parameter int NUM_STAGES = 8,
   parameter int CODE_W     = 2,
   parameter int OUT_W      = 10
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_STAGES*CODE_W-1:0] stage_codes,
   input  logic [CODE_W-1:0]            flash_code,
   input  logic                         fmt_twos,
   output logic [OUT_W-1:0]             data_out
);

   import pa_pkg::*;

   localparam int LANES_W = NUM_STAGES * CODE_W;

   generate
      if ((NUM_STAGES % 2) != 0) begin : g_bad_stages
         $error("NUM_STAGES must be even");
      end
      if (CODE_W != 2) begin : g_bad_code
         $error("CODE_W must be 2 for one-bit overlap");
      end
      if (OUT_W != NUM_STAGES + 2) begin : g_bad_out
         $error("OUT_W must equal NUM_STAGES + 2");
      end
   endgenerate

   logic [LANES_W-1:0] rise_codes;
   logic [CODE_W-1:0]  flash_rise;
   logic [LANES_W-1:0] aligned;
   logic [OUT_W-1:0]   sat_word;

   pa_stage_capture #(.NUM_STAGES(NUM_STAGES), .CODE_W(CODE_W)) u_capture (
      .clk           (clk),
      .rst_n         (rst_n),
      .stage_codes_i (stage_codes),
      .flash_i       (flash_code),
      .rise_codes_o  (rise_codes),
      .flash_o       (flash_rise)
   );

   genvar gl;
   generate
      for (gl = 0; gl < NUM_STAGES; gl++) begin : g_align
         pa_align_delay #(.WIDTH(CODE_W), .DEPTH(lane_delay(NUM_STAGES, gl))) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (rise_codes[gl*CODE_W +: CODE_W]),
            .dout  (aligned[gl*CODE_W +: CODE_W])
         );
      end
   endgenerate

   pa_overlap_add #(.NUM_STAGES(NUM_STAGES), .CODE_W(CODE_W), .OUT_W(OUT_W)) u_add (
      .clk       (clk),
      .rst_n     (rst_n),
      .aligned_i (aligned),
      .flash_i   (flash_rise),
      .sat_o     (sat_word)
   );

   pa_format_out #(.OUT_W(OUT_W)) u_fmt (
      .clk        (clk),
      .rst_n      (rst_n),
      .sat_i      (sat_word),
      .fmt_twos_i (fmt_twos),
      .data_o     (data_out)
   );

   // R8
   reset_quiet_chk: assert property (@(posedge clk)
      (!rst_n) |-> (data_out == '0));

   // R4
   low_bits_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_out[OUT_W-2:0] == $past(sat_word[OUT_W-2:0], 2));

   // R7
   msb_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_out[OUT_W-1] == ($past(sat_word[OUT_W-1], 2) ^ $past(fmt_twos, 2)));

endmodule

// File: tb/pa_backend_top_tb.sv
module pa_backend_top_tb;

   localparam int NS    = 8;
   localparam int NSAMP = 1200;
   localparam int LAT   = 7;
   localparam int REL   = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [2*NS-1:0] stage_codes;
   logic [1:0]    flash_code;
   logic          fmt_twos;
   logic [9:0]    data_out;

   int checks = 0;
   int fails  = 0;
   int e;
   bit done = 0;

   logic [1:0] codes [0:NSAMP-1][0:NS];
   logic       fmt_hist [0:NSAMP+20];

   always #4 clk = ~clk;

   pa_backend_top u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .stage_codes (stage_codes),
      .flash_code  (flash_code),
      .fmt_twos    (fmt_twos),
      .data_out    (data_out)
   );

   function automatic logic [1:0] code_of(input int n, input int k);
      if (n < 0 || n >= NSAMP) return 2'd0;
      return codes[n][k];
   endfunction

   function automatic int expect_word(input int n, input logic fm, output bit sat);
      int s;
      s = int'(code_of(n, NS));
      for (int k = 1; k <= NS; k++) s += int'(code_of(n, k - 1)) << (9 - k);
      sat = (s > 1023);
      if (sat) s = 1023;
      if (fm) s = s ^ 512;
      return s;
   endfunction

   task automatic drive_rise(input int ee);
      for (int j = 0; j < NS / 2; j++) stage_codes[(2*j)*2 +: 2] = code_of(ee - j, 2*j);
      flash_code = code_of(ee - NS / 2, NS);
      fmt_twos   = (ee >= 500) ? (((ee / 23) % 2) == 1) : 1'b0;
      if (ee >= 0 && ee <= NSAMP + 20) fmt_hist[ee] = fmt_twos;
   endtask

   task automatic drive_fall(input int ee);
      for (int j = 0; j < NS / 2; j++) stage_codes[(2*j+1)*2 +: 2] = code_of(ee - j, 2*j + 1);
   endtask

   task automatic check_edge(input int ee);
      int  exp_v;
      bit  sat;
      if (ee < REL) begin
         checks++;
         if (data_out !== 10'd0) begin
            fails++;
            $display("FAIL R8 edge %0d: data_out=%0d expected 0", ee, data_out);
         end
      end else if (ee >= REL + LAT && ee - LAT < NSAMP) begin
         exp_v = expect_word(ee - LAT, fmt_hist[ee - 1], sat);
         checks++;
         if (data_out !== exp_v[9:0]) begin
            fails++;
            $display("FAIL %s sample %0d: data_out=%0d expected %0d",
                     sat ? "R6" : (fmt_hist[ee-1] ? "R7" : "R1 R2 R3 R4 R5"),
                     ee - LAT, data_out, exp_v);
         end
      end
   endtask

   initial begin
      for (int n = 0; n < NSAMP; n++)
         for (int k = 0; k <= NS; k++) codes[n][k] = 2'($urandom_range(0, 3));
      // R5: all-zero run must give zero
      for (int n = 100; n < 110; n++) for (int k = 0; k <= NS; k++) codes[n][k] = 2'd0;
      // R6: all-three run saturates
      for (int n = 200; n < 210; n++) for (int k = 0; k <= NS; k++) codes[n][k] = 2'd3;
      // R6 boundary: exactly 1023, then 1025 clamped, then 1022
      for (int k = 0; k < NS; k++) begin
         codes[300][k] = 2'd2; codes[301][k] = 2'd2; codes[302][k] = 2'd2;
         codes[303][k] = 2'd0; codes[304][k] = (k % 2 == 0) ? 2'd1 : 2'd2;
      end
      codes[300][NS] = 2'd3;
      codes[301][NS-1] = 2'd3; codes[301][NS] = 2'd3;
      codes[302][NS] = 2'd2;
      // R5: stage 1 alone carries weight 256 times its code
      codes[303][0] = 2'd3; codes[303][NS] = 2'd0;
      codes[304][NS] = 2'd1;
      // R3: isolated single-sample spike among zeros
      for (int n = 400; n < 412; n++) for (int k = 0; k <= NS; k++) codes[n][k] = 2'd0;
      codes[405][7] = 2'd3; codes[405][NS] = 2'd1;
      // R7: same boundary values under two's complement
      for (int k = 0; k <= NS; k++) begin
         codes[620][k] = 2'd3; codes[621][k] = 2'd0;
      end
   end

   initial begin
      rst_n = 1'b0;
      stage_codes = '0;
      flash_code = '0;
      fmt_twos = 1'b0;
      e = -1;
      drive_rise(0);
      for (int it = 0; it < NSAMP + LAT + 4; it++) begin
         @(posedge clk);
         e = e + 1;
         #1;
         drive_fall(e);
         #2;
         check_edge(e);
         @(negedge clk);
         #1;
         if (e == REL - 1) rst_n = 1'b1;
         drive_rise(e + 1);
      end
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: run did not end, actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule